// File: doc/BRIEF.md
# 1-Wire ROM Command Selector

This block is the network layer of a 1-Wire slave. The bit-level signalling layer below it tells it when a bus reset was seen and whether that reset was long. It also passes up each bit the master wrote and raises a request at the start of each read slot. After every reset the selector collects an 8-bit ROM command, least significant bit first. It then either streams out its 64-bit identity, compares the identity against bits the master sends, or takes part in the bitwise search arbitration. At the end it decides whether the memory layer above may run.

The identity is fixed at elaboration from two parameters, a family code and a 48-bit serial. The checksum byte is computed from them. The selector also owns the speed flag that tells the signalling layer to use fast timing. Two commands raise it. A long reset clears it, and a short reset leaves it as it was.

Top module: `owr_rom_selector`

## Requirements
- R1: After the synchronous reset `rst`, `selected` is 0, `od_set` is 0 and `tx_bit` is 1 (line released).
- R2: Command bits arrive LSB first after each `reset_seen`. The code CCh asserts `selected` from the edge that takes the 8th bit and leaves `od_set` unchanged.
- R3: Code 33h makes `tx_bit` present identity bit i, starting at i=0, for the i-th read request. After 64 requests `tx_bit` stays 1 and `selected` stays 0.
- R4: Code 55h compares the next 64 written bits with the identity, LSB first. If all 64 are equal, `selected` rises on the edge that takes bit 63. On any unequal bit the device ignores the rest of the traffic until the next reset and is never selected.
- R5: Code F0h runs the search: for each bit i, the first read gives identity bit i, the second gives its inverse, and then a written bit is taken. A written bit unequal to bit i, or the completion of all 64 bits, leaves the device idle with `tx_bit` at 1 and `selected` at 0.
- R6: Code 3Ch asserts both `selected` and `od_set` from the edge that takes the 8th command bit.
- R7: Code 69h sets `od_set` after the command byte and then matches 64 bits as in R4. On success `od_set` stays 1. On a mismatch `od_set` returns to the value it had before the command.
- R8: `reset_seen` deselects the device and restarts command collection. With `reset_long` at 1 it clears `od_set`. With `reset_long` at 0 it leaves `od_set` unchanged.
- R9: Any other command code leaves the device idle until the next reset: no selection, `tx_bit` at 1, and later bits have no effect.
- R10: The identity holds the family code in bits 7:0, the serial in bits 55:8, and in bits 63:56 the CRC of bits 55:0. That CRC is generator x8+x5+x4+1, starts from zero and is fed LSB first. Running the same CRC over all 64 bits gives zero.
- R11: When `reset_seen` falls in the same cycle as a written bit or a read request, the reset wins and the bit is discarded.
- R12: A written bit during a phase that expects a read request, or a read request during a phase that expects a written bit, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_seen | input | 1 | One-cycle pulse: bus reset detected |
| reset_long | input | 1 | Qualifies `reset_seen`: reset long enough to leave fast speed |
| rx_valid | input | 1 | One-cycle pulse: master wrote a bit |
| rx_bit | input | 1 | Value of the written bit |
| tx_req | input | 1 | One-cycle pulse: master opened a read slot |
| tx_bit | output | 1 | Bit presented for the current read slot (1 = release) |
| selected | output | 1 | Memory layer may run |
| od_set | output | 1 | Fast signalling speed requested |

## Verification
Two events can land in the same cycle: a bus reset and the bit that would complete a match or a command byte. The bench raises `reset_seen` and `rx_valid` together on the 64th match bit and then checks that `selected` stays low. It then checks that a fresh skip byte still selects the device, which proves the colliding bit never entered the command shifter. The speed flag has a similar conflict. A failed fast match must restore the earlier speed, so the bench runs that mismatch once from regular speed and once after a fast skip plus a short reset, and judges `od_set` in each case.

// File: rtl/owr_pkg.sv
package owr_pkg;

    localparam int ID_W   = 64;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CMD_READ   = 8'h33;
    localparam logic [CODE_W-1:0] CMD_MATCH  = 8'h55;
    localparam logic [CODE_W-1:0] CMD_SEARCH = 8'hF0;
    localparam logic [CODE_W-1:0] CMD_SKIP   = 8'hCC;
    localparam logic [CODE_W-1:0] CMD_FSKIP  = 8'h3C;
    localparam logic [CODE_W-1:0] CMD_FMATCH = 8'h69;

    typedef enum logic [2:0] {
        ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_SEL, ST_DEAD
    } rom_state_e;

    typedef enum logic [1:0] {
        PH_TRUE, PH_CMPL, PH_WRITE
    } srch_phase_e;

    // One step of the reflected x8+x5+x4+1 checksum
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? 8'h8C : 8'h00);
    endfunction

    function automatic logic [7:0] crc8_low56(input logic [ID_W-1:0] d);
        logic [7:0] c;
        c = '0;
        for (int i = 0; i < 56; i++) c = crc8_step(c, d[i]);
        return c;
    endfunction

    function automatic logic [7:0] crc8_all64(input logic [ID_W-1:0] d);
        logic [7:0] c;
        c = '0;
        for (int i = 0; i < ID_W; i++) c = crc8_step(c, d[i]);
        return c;
    endfunction

    function automatic logic [ID_W-1:0] id_build(input logic [7:0] fam, input logic [47:0] ser);
        logic [ID_W-1:0] v;
        v = {8'h00, ser, fam};
        v[63:56] = crc8_low56(v);
        return v;
    endfunction

endpackage

// File: rtl/owr_cmd_shift.sv
module owr_cmd_shift #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic          rx_valid,
    input  logic          rx_bit,
    output logic          done,
    output logic [CW-1:0] code
);
    localparam int CNT_W = $clog2(CW);

    logic [CW-1:0]    sh;
    logic [CNT_W-1:0] cnt;

    assign done = en && rx_valid && (cnt == CNT_W'(CW - 1));
    assign code = {rx_bit, sh[CW-1:1]};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh  <= '0;
            cnt <= '0;
        end else if (en && rx_valid) begin
            sh  <= {rx_bit, sh[CW-1:1]};
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/owr_id_cursor.sv
module owr_id_cursor #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] id,
    output logic         cur_bit,
    output logic         last
);
    localparam int IW = $clog2(W);

    logic [IW-1:0] idx;

    assign cur_bit = id[idx];
    assign last    = (idx == IW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)         idx <= '0;
        else if (adv && !last)  idx <= idx + 1'b1;
    end
endmodule

// File: rtl/owr_speed_ctl.sv
module owr_speed_ctl (
    input  logic clk,
    input  logic rst,
    input  logic slow_now,
    input  logic go_fast,
    input  logic restore,
    output logic od
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            od   <= 1'b0;
            prev <= 1'b0;
        end else if (slow_now) begin
            od   <= 1'b0;
            prev <= 1'b0;
        end else if (go_fast) begin
            prev <= od;
            od   <= 1'b1;
        end else if (restore) begin
            od   <= prev;
        end
    end

    // R8
    od_long_chk: assert property (@(posedge clk) disable iff (rst)
        $past(slow_now) |-> !od);

    // R7
    od_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(od) |-> $past(go_fast));
endmodule

// File: rtl/owr_rom_selector.sv
module owr_rom_selector
    import owr_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h1A,
    parameter logic [47:0] SERIAL = 48'h5C3A_91E0_4D27
) (
    input  logic clk,
    input  logic rst,
    input  logic reset_seen,
    input  logic reset_long,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic tx_req,
    output logic tx_bit,
    output logic selected,
    output logic od_set
);
    localparam logic [ID_W-1:0] ID = id_build(FAMILY, SERIAL);

    // R10
    initial begin
        id_crc_chk: assert (crc8_all64(ID) == 8'h00)
            else $error("identity checksum does not close");
    end

    rom_state_e   st, st_n;
    srch_phase_e  ph, ph_n;
    logic         fm, fm_n;
    logic         cmd_done;
    logic [CODE_W-1:0] code;
    logic         cur_bit, last, cur_adv, cur_clr;
    logic         go_fast, restore;

    owr_cmd_shift #(.CW(CODE_W)) u_cmd (
        .clk(clk), .rst(rst),
        .clr(reset_seen || st != ST_CMD),
        .en(st == ST_CMD && !reset_seen),
        .rx_valid(rx_valid), .rx_bit(rx_bit),
        .done(cmd_done), .code(code)
    );

    assign cur_clr = reset_seen || st == ST_CMD;

    owr_id_cursor #(.W(ID_W)) u_cur (
        .clk(clk), .rst(rst), .clr(cur_clr), .adv(cur_adv),
        .id(ID), .cur_bit(cur_bit), .last(last)
    );

    owr_speed_ctl u_spd (
        .clk(clk), .rst(rst),
        .slow_now(reset_seen && reset_long),
        .go_fast(go_fast), .restore(restore),
        .od(od_set)
    );

    always_comb begin
        st_n    = st;
        ph_n    = ph;
        fm_n    = fm;
        cur_adv = 1'b0;
        go_fast = 1'b0;
        restore = 1'b0;
        if (reset_seen) begin
            st_n = ST_CMD;
            ph_n = PH_TRUE;
            fm_n = 1'b0;
        end else begin
            unique case (st)
                ST_CMD: if (cmd_done) begin
                    fm_n = 1'b0;
                    ph_n = PH_TRUE;
                    case (code)
                        CMD_READ:   st_n = ST_READ;
                        CMD_MATCH:  st_n = ST_MATCH;
                        CMD_SEARCH: st_n = ST_SEARCH;
                        CMD_SKIP:   st_n = ST_SEL;
                        CMD_FSKIP: begin
                            st_n    = ST_SEL;
                            go_fast = 1'b1;
                        end
                        CMD_FMATCH: begin
                            st_n    = ST_MATCH;
                            fm_n    = 1'b1;
                            go_fast = 1'b1;
                        end
                        default:    st_n = ST_DEAD;
                    endcase
                end
                ST_READ: if (tx_req) begin
                    if (last) st_n = ST_DEAD;
                    else      cur_adv = 1'b1;
                end
                ST_MATCH: if (rx_valid) begin
                    if (rx_bit != cur_bit) begin
                        st_n    = ST_DEAD;
                        restore = fm;
                    end else if (last) begin
                        st_n = ST_SEL;
                    end else begin
                        cur_adv = 1'b1;
                    end
                end
                ST_SEARCH: begin
                    case (ph)
                        PH_TRUE: if (tx_req) ph_n = PH_CMPL;
                        PH_CMPL: if (tx_req) ph_n = PH_WRITE;
                        PH_WRITE: if (rx_valid) begin
                            if (rx_bit != cur_bit || last) begin
                                st_n = ST_DEAD;
                            end else begin
                                cur_adv = 1'b1;
                                ph_n    = PH_TRUE;
                            end
                        end
                        default: ph_n = PH_TRUE;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_DEAD;
            ph <= PH_TRUE;
            fm <= 1'b0;
        end else begin
            st <= st_n;
            ph <= ph_n;
            fm <= fm_n;
        end
    end

    always_comb begin
        tx_bit = 1'b1;
        if (st == ST_READ)
            tx_bit = cur_bit;
        else if (st == ST_SEARCH && ph == PH_TRUE)
            tx_bit = cur_bit;
        else if (st == ST_SEARCH && ph == PH_CMPL)
            tx_bit = ~cur_bit;
    end

    assign selected = (st == ST_SEL);

    // R4
    sel_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(selected) |-> $past(rx_valid) && !$past(reset_seen));

    // R8
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reset_seen) |-> !selected);

    // R8
    od_short_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reset_seen && !reset_long) |-> od_set == $past(od_set));

    // R9
    dead_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(st == ST_DEAD && !reset_seen) |-> !selected && tx_bit);
endmodule

// File: tb/tb_owr_rom_selector.sv
module tb_owr_rom_selector;
    localparam logic [7:0]  FAM = 8'h1A;
    localparam logic [47:0] SER = 48'h5C3A_91E0_4D27;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reset_seen = 1'b0, reset_long = 1'b0;
    logic rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
    logic tx_bit, selected, od_set;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    owr_rom_selector #(.FAMILY(FAM), .SERIAL(SER)) dut (
        .clk(clk), .rst(rst), .reset_seen(reset_seen), .reset_long(reset_long),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req),
        .tx_bit(tx_bit), .selected(selected), .od_set(od_set)
    );

    function automatic logic [7:0] bcrc(input logic [63:0] v, input int n);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic x = r[0] ^ v[i];
            r = {x, r[7:5], r[4] ^ x, r[3] ^ x, r[2:1]};
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_id();
        logic [63:0] v = {8'h00, SER, FAM};
        v[63:56] = bcrc(v, 56);
        return v;
    endfunction

    logic [63:0] ID;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_reset(input logic lng);
        @(negedge clk);
        reset_seen = 1'b1; reset_long = lng;
        @(negedge clk);
        reset_seen = 1'b0; reset_long = 1'b0;
    endtask

    task automatic wr_bit(input logic b);
        rx_valid = 1'b1; rx_bit = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rd_bit(output logic b);
        b = tx_bit;
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr_bit(v[i]);
    endtask

    task automatic wr_id(input int flip);
        for (int i = 0; i < 64; i++) wr_bit(ID[i] ^ (i == flip));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic b;
        logic [63:0] got;
        int unsigned sd;
        ID = exp_id();
        sd = $urandom(24680);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 selected", selected, 0);
        chk("R1 od_set", od_set, 0);
        chk("R1 tx_bit", tx_bit, 1);

        // R2: skip
        bus_reset(1); wr_byte(8'hCC);
        chk("R2 skip selects", selected, 1);
        chk("R2 skip keeps speed", od_set, 0);

        // R3 / R10: read identity, with R12 writes mixed in
        bus_reset(1); wr_byte(8'h33);
        for (int i = 0; i < 64; i++) begin
            if (i == 10) wr_bit(1'b0); // R12: ignored in read phase
            rd_bit(b); got[i] = b;
        end
        chk("R3 identity stream", got, ID);
        chk("R10 family byte", got[7:0], FAM);
        chk("R10 checksum byte", got[63:56], bcrc({8'h00, SER, FAM}, 56));
        rd_bit(b);
        chk("R3 released after 64", b, 1);
        chk("R3 not selected", selected, 0);

        // R4: match success, with a stray read request (R12)
        bus_reset(1); wr_byte(8'h55);
        rd_bit(b);
        chk("R12 read in match phase", b, 1);
        wr_id(-1);
        chk("R4 full match", selected, 1);

        // R4: mismatch on bit 0 and bit 63
        bus_reset(1); wr_byte(8'h55); wr_id(0);
        chk("R4 mismatch bit0", selected, 0);
        bus_reset(1); wr_byte(8'h55); wr_id(63);
        chk("R4 mismatch bit63", selected, 0);

        // R5: full search
        bus_reset(1); wr_byte(8'hF0);
        begin
            logic ok = 1;
            for (int i = 0; i < 64; i++) begin
                logic t, c;
                rd_bit(t); rd_bit(c);
                if (t !== ID[i] || c !== ~ID[i]) ok = 0;
                wr_bit(ID[i]);
            end
            chk("R5 search pairs", ok, 1);
        end
        rd_bit(b);
        chk("R5 idle after search", b, 1);
        chk("R5 search not selected", selected, 0);

        // R6 / R8
        bus_reset(1); wr_byte(8'h3C);
        chk("R6 fast skip selects", selected, 1);
        chk("R6 fast skip speed", od_set, 1);
        bus_reset(0);
        chk("R8 short keeps speed", od_set, 1);
        chk("R8 short deselects", selected, 0);
        bus_reset(1);
        chk("R8 long clears speed", od_set, 0);

        // R7
        bus_reset(1); wr_byte(8'h69);
        chk("R7 fast after command", od_set, 1);
        wr_id(-1);
        chk("R7 fast match selects", selected, 1);
        chk("R7 fast kept", od_set, 1);
        bus_reset(1); wr_byte(8'h69); wr_id(17);
        chk("R7 mismatch back to regular", od_set, 0);
        chk("R7 mismatch not selected", selected, 0);
        bus_reset(1); wr_byte(8'h3C); bus_reset(0); wr_byte(8'h69); wr_id(5);
        chk("R7 mismatch stays fast", od_set, 1);

        // R9
        bus_reset(1); wr_byte(8'h5A);
        chk("R9 unknown not selected", selected, 0);
        wr_byte(8'hCC);
        chk("R9 later bits ignored", selected, 0);
        rd_bit(b);
        chk("R9 line released", b, 1);

        // R11: reset collides with last match bit
        bus_reset(1); wr_byte(8'h55);
        for (int i = 0; i < 63; i++) wr_bit(ID[i]);
        reset_seen = 1'b1; reset_long = 1'b1; rx_valid = 1'b1; rx_bit = ID[63];
        @(negedge clk);
        reset_seen = 1'b0; reset_long = 1'b0; rx_valid = 1'b0;
        chk("R11 reset wins", selected, 0);
        wr_byte(8'hCC);
        chk("R11 bit discarded", selected, 1);

        // random mix
        for (int t = 0; t < 24; t++) begin
            int mode = int'($urandom % 3);
            int k = int'($urandom % 64);
            bus_reset(1);
            if (mode == 0) begin
                wr_byte(8'h55); wr_id(-1);
                chk("R4 random match", selected, 1);
            end else if (mode == 1) begin
                wr_byte(8'h55); wr_id(k);
                chk("R4 random mismatch", {selected, tx_bit}, 2'b01);
            end else begin
                logic ok = 1;
                wr_byte(8'hF0);
                for (int i = 0; i <= k; i++) begin
                    logic tb_t, tb_c;
                    rd_bit(tb_t); rd_bit(tb_c);
                    if (tb_t !== ID[i] || tb_c !== ~ID[i]) ok = 0;
                    wr_bit(i == k ? ~ID[i] : ID[i]);
                end
                rd_bit(b);
                chk("R5 random dropout", {ok, b, selected}, 3'b110);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule